// File: doc/BRIEF.md
# Bus Address Remapper

This block translates bus master addresses before the memory decode of a multi-master bus. Each request carries a master class and a 32-bit virtual address. Purely combinational logic turns them into a 32-bit physical address and a target select: nonvolatile memory, on-chip SRAM, DDR, or unmapped. Two control words set the mapping, and each master class is remapped on its own terms.

System masters boot with nonvolatile memory at address zero. They can instead see a chosen slice of DDR there. That cacheable slice is 128 MB, 256 MB or 512 MB wide, and an index picks which sub-region of a 512 MB area inside the current 1 GB DDR window it maps to. System and fabric masters reach DDR through a 1 GB window aperture. Fabric masters can see a 4 KB-aligned segment of nonvolatile memory at address zero. DMA-class masters are never remapped and reach all 4 GB of DDR directly.

Physical map of the default build:
- Nonvolatile memory: 0x6000_0000–0x6FFF_FFFF.
- SRAM: 0x2000_0000–0x2000_FFFF.
- DDR window aperture: 0x8000_0000–0xBFFF_FFFF.
- Low zone: 0x0000_0000–0x1FFF_FFFF.

For DDR targets the physical address is the DDR byte offset.

Top module: `bus_addr_remap`

## Requirements
- R1: After reset every control field is zero and both control words read back 0. A system-class request to 0x0000_0000 then yields target NVM with physical address 0x6000_0000.
- R2: Register word 0 holds the fabric enable in bit 31 and the segment offset, in 4 KB units, in bits 15:0. Word 1 holds the DDR remap enable in bit 0, the window select in bits 5:4, the size in bits 9:8 and the region index in bits 13:12. Reads return only these fields, with every other bit zero. Words 2 and 3 read 0, and writes to them change nothing.
- R3: Master class codes are 0 for system, 1 for DMA, 2 for fabric and 3 for system. Target codes are 0 NVM, 1 SRAM, 2 DDR and 3 unmapped. SRAM addresses map to themselves with target SRAM for every class and every setting.
- R4: Addresses in the nonvolatile range map to themselves with target NVM for every class.
- R5: With DDR remap off, a system address below 0x1000_0000 maps to NVM at 0x6000_0000 plus the address. A system address from 0x1000_0000 to 0x1FFF_FFFF is unmapped.
- R6: With fabric remap on, a fabric address A below 0x1000_0000 maps to NVM at 0x6000_0000 + offset*4096 + A. It is unmapped when offset*4096 + A reaches 0x1000_0000. With fabric remap off, fabric low-zone addresses are unmapped. DDR remap never affects fabric masters.
- R7: For system and fabric classes, an address in 0x8000_0000–0xBFFF_FFFF maps to DDR offset window*2^30 + (A − 0x8000_0000).
- R8: With DDR remap on, a system address A below the selected size maps to DDR offset window*2^30 + index*size + A. Sizes are encoded 0 = 128 MB, 1 = 256 MB, 2 or 3 = 512 MB. A low-zone address at or above the size is unmapped.
- R9: At 256 MB only index bit 12 is used. At 512 MB the index is ignored.
- R10: DMA-class addresses outside SRAM and nonvolatile memory map to DDR with the physical address equal to the virtual address. A DMA request is never unmapped.
- R11: An unmapped request passes its virtual address through unchanged, and the unmapped flag is high exactly when the target is 3.
- R12: Translation follows address and class changes with no clock. A register write changes the translation from the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read-back data |
| mst_class_i | input | 2 | Requesting master class |
| vaddr_i | input | 32 | Virtual address |
| paddr_o | output | 32 | Translated physical address |
| target_o | output | 2 | Target select |
| unmapped_o | output | 1 | High when no target matches |

## Verification
The assertions sample the combinational outputs at the clock edge. They therefore assume the class and address inputs are settled and known there, never X, once reset is released. The bench meets this in two ways. It changes the request inputs only at falling edges or between edges, with reset already released. It also drives every input to a defined value from time zero, so the clocked properties only ever see settled request values.

// File: rtl/remap_pkg.sv
package remap_pkg;

  localparam int unsigned OFF_W  = 16;
  localparam int unsigned SEL_W  = 2;

  typedef enum logic [1:0] {
    TGT_NVM  = 2'd0,
    TGT_SRAM = 2'd1,
    TGT_DDR  = 2'd2,
    TGT_NONE = 2'd3
  } target_e;

  typedef enum logic [1:0] {
    CLS_SYS     = 2'd0,
    CLS_DMA     = 2'd1,
    CLS_FAB     = 2'd2,
    CLS_SYS_ALT = 2'd3
  } class_e;

  typedef struct packed {
    logic             fab_en;
    logic [OFF_W-1:0] fab_off;
    logic             ddr_en;
    logic [SEL_W-1:0] win_sel;
    logic [1:0]       sub_size;
    logic [1:0]       sub_idx;
  } remap_cfg_t;

endpackage

// File: rtl/remap_regs.sv
module remap_regs
  import remap_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output remap_cfg_t  cfg_o
);

  remap_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i) begin
      case (addr_i)
        2'd0: begin
          cfg_q.fab_en  <= wdata_i[31];
          cfg_q.fab_off <= wdata_i[OFF_W-1:0];
        end
        2'd1: begin
          cfg_q.ddr_en   <= wdata_i[0];
          cfg_q.win_sel  <= wdata_i[5:4];
          cfg_q.sub_size <= wdata_i[9:8];
          cfg_q.sub_idx  <= wdata_i[13:12];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      2'd0:    rdata_o = {cfg_q.fab_en, {(31-OFF_W){1'b0}}, cfg_q.fab_off};
      2'd1:    rdata_o = {18'b0, cfg_q.sub_idx, 2'b0, cfg_q.sub_size, 2'b0,
                          cfg_q.win_sel, 3'b0, cfg_q.ddr_en};
      default: rdata_o = 32'd0;
    endcase
  end

  assign cfg_o = cfg_q;

  p_fab_write_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd0) |=> (cfg_q.fab_en == $past(wdata_i[31]) &&
                                  cfg_q.fab_off == $past(wdata_i[OFF_W-1:0])));

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i || addr_i[1]) |=> $stable(cfg_q));

endmodule

// File: rtl/remap_lowzone.sv
module remap_lowzone
  import remap_pkg::*;
#(
  parameter int unsigned AW           = 32,
  parameter logic [31:0] NVM_BASE     = 32'h6000_0000,
  parameter int unsigned NVM_LOG2     = 28,
  parameter int unsigned SEG_LOG2     = 12,
  parameter int unsigned WIN_LOG2     = 30,
  parameter int unsigned SUB_MIN_LOG2 = 27
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  remap_cfg_t    cfg_i,
  input  logic [AW-1:0] vaddr_i,
  output logic          fab_hit_o,
  output logic [AW-1:0] fab_pa_o,
  output logic          ddr_hit_o,
  output logic [AW-1:0] ddr_pa_o
);

  localparam logic [4:0] L_SMALL = 5'(SUB_MIN_LOG2);
  localparam logic [4:0] L_MID   = 5'(SUB_MIN_LOG2 + 1);
  localparam logic [4:0] L_LARGE = 5'(SUB_MIN_LOG2 + 2);

  logic [4:0]  sub_log2;
  logic [1:0]  idx_eff;
  logic [AW:0] seg_sum;

  // size code 2 and 3 both mean the full cacheable span
  always_comb begin
    case (cfg_i.sub_size)
      2'b00:   begin sub_log2 = L_SMALL; idx_eff = cfg_i.sub_idx;          end
      2'b01:   begin sub_log2 = L_MID;   idx_eff = {1'b0, cfg_i.sub_idx[0]}; end
      default: begin sub_log2 = L_LARGE; idx_eff = 2'b00;                  end
    endcase
  end

  assign ddr_hit_o = cfg_i.ddr_en && ((vaddr_i >> sub_log2) == '0);
  assign ddr_pa_o  = (AW'(cfg_i.win_sel) << WIN_LOG2)
                   + (AW'(idx_eff) << sub_log2)
                   + vaddr_i;

  assign seg_sum   = ((AW+1)'(cfg_i.fab_off) << SEG_LOG2) + {1'b0, vaddr_i};
  assign fab_hit_o = cfg_i.fab_en && ((vaddr_i >> NVM_LOG2) == '0)
                   && ((seg_sum >> NVM_LOG2) == '0);
  assign fab_pa_o  = NVM_BASE + seg_sum[AW-1:0];

  p_ddr_in_window_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ddr_hit_o |-> ((ddr_pa_o >> WIN_LOG2) == AW'(cfg_i.win_sel)));

  p_fab_in_nvm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fab_hit_o |-> ((fab_pa_o >> NVM_LOG2) == (NVM_BASE >> NVM_LOG2)));

endmodule

// File: rtl/remap_xlate.sv
module remap_xlate
  import remap_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter logic [31:0] NVM_BASE   = 32'h6000_0000,
  parameter int unsigned NVM_LOG2   = 28,
  parameter logic [31:0] SRAM_BASE  = 32'h2000_0000,
  parameter int unsigned SRAM_LOG2  = 16,
  parameter logic [31:0] WIN_BASE   = 32'h8000_0000,
  parameter int unsigned WIN_LOG2   = 30,
  parameter int unsigned CACHE_LOG2 = 29
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    cls_i,
  input  logic [AW-1:0] vaddr_i,
  input  logic          ddr_remap_i,
  input  logic [1:0]    win_sel_i,
  input  logic          fab_hit_i,
  input  logic [AW-1:0] fab_pa_i,
  input  logic          ddr_hit_i,
  input  logic [AW-1:0] ddr_pa_i,
  output logic [AW-1:0] paddr_o,
  output target_e       target_o
);

  logic in_sram, in_nvm, in_win, in_low, in_boot;
  logic [AW-1:0] win_pa;

  assign in_sram = (vaddr_i >> SRAM_LOG2) == (SRAM_BASE >> SRAM_LOG2);
  assign in_nvm  = (vaddr_i >> NVM_LOG2)  == (NVM_BASE >> NVM_LOG2);
  assign in_win  = (vaddr_i >> WIN_LOG2)  == (WIN_BASE >> WIN_LOG2);
  assign in_low  = (vaddr_i >> CACHE_LOG2) == '0;
  assign in_boot = (vaddr_i >> NVM_LOG2) == '0;
  assign win_pa  = (AW'(win_sel_i) << WIN_LOG2)
                 + (vaddr_i & ((AW'(1) << WIN_LOG2) - AW'(1)));

  always_comb begin
    paddr_o  = vaddr_i;
    target_o = TGT_NONE;
    if (in_sram) begin
      target_o = TGT_SRAM;
    end else if (in_nvm) begin
      target_o = TGT_NVM;
    end else begin
      case (class_e'(cls_i))
        CLS_DMA: target_o = TGT_DDR;
        CLS_FAB: begin
          if (in_win) begin
            target_o = TGT_DDR;
            paddr_o  = win_pa;
          end else if (in_low && fab_hit_i) begin
            target_o = TGT_NVM;
            paddr_o  = fab_pa_i;
          end
        end
        default: begin
          if (in_win) begin
            target_o = TGT_DDR;
            paddr_o  = win_pa;
          end else if (in_low && ddr_remap_i) begin
            if (ddr_hit_i) begin
              target_o = TGT_DDR;
              paddr_o  = ddr_pa_i;
            end
          end else if (in_boot) begin
            target_o = TGT_NVM;
            paddr_o  = NVM_BASE + vaddr_i;
          end
        end
      endcase
    end
  end

  p_none_passthru_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (target_o == TGT_NONE) |-> (paddr_o == vaddr_i));

  p_sram_fixed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((vaddr_i >> SRAM_LOG2) == (SRAM_BASE >> SRAM_LOG2))
      |-> (target_o == TGT_SRAM && paddr_o == vaddr_i));

  p_dma_mapped_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_i == CLS_DMA) |-> (target_o != TGT_NONE));

  p_nvm_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (target_o == TGT_NVM) |-> ((paddr_o >> NVM_LOG2) == (NVM_BASE >> NVM_LOG2)));

  p_fab_low_no_ddr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_i == CLS_FAB && (vaddr_i >> CACHE_LOG2) == '0) |-> (target_o != TGT_DDR));

endmodule

// File: rtl/bus_addr_remap.sv
module bus_addr_remap
  import remap_pkg::*;
#(
  parameter int unsigned AW           = 32,
  parameter logic [31:0] NVM_BASE     = 32'h6000_0000,
  parameter int unsigned NVM_LOG2     = 28,
  parameter logic [31:0] SRAM_BASE    = 32'h2000_0000,
  parameter int unsigned SRAM_LOG2    = 16,
  parameter logic [31:0] WIN_BASE     = 32'h8000_0000,
  parameter int unsigned WIN_LOG2     = 30,
  parameter int unsigned SEG_LOG2     = 12,
  parameter int unsigned SUB_MIN_LOG2 = 27
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  logic [1:0]    mst_class_i,
  input  logic [AW-1:0] vaddr_i,
  output logic [AW-1:0] paddr_o,
  output logic [1:0]    target_o,
  output logic          unmapped_o
);

  localparam int unsigned CACHE_LOG2 = SUB_MIN_LOG2 + 2;

  remap_cfg_t    cfg;
  logic          fab_hit, ddr_hit;
  logic [AW-1:0] fab_pa, ddr_pa;
  target_e       tgt;

  remap_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .cfg_o   (cfg)
  );

  remap_lowzone #(
    .AW(AW), .NVM_BASE(NVM_BASE), .NVM_LOG2(NVM_LOG2), .SEG_LOG2(SEG_LOG2),
    .WIN_LOG2(WIN_LOG2), .SUB_MIN_LOG2(SUB_MIN_LOG2)
  ) u_lowzone (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_i     (cfg),
    .vaddr_i   (vaddr_i),
    .fab_hit_o (fab_hit),
    .fab_pa_o  (fab_pa),
    .ddr_hit_o (ddr_hit),
    .ddr_pa_o  (ddr_pa)
  );

  remap_xlate #(
    .AW(AW), .NVM_BASE(NVM_BASE), .NVM_LOG2(NVM_LOG2), .SRAM_BASE(SRAM_BASE),
    .SRAM_LOG2(SRAM_LOG2), .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2),
    .CACHE_LOG2(CACHE_LOG2)
  ) u_xlate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cls_i       (mst_class_i),
    .vaddr_i     (vaddr_i),
    .ddr_remap_i (cfg.ddr_en),
    .win_sel_i   (cfg.win_sel),
    .fab_hit_i   (fab_hit),
    .fab_pa_i    (fab_pa),
    .ddr_hit_i   (ddr_hit),
    .ddr_pa_i    (ddr_pa),
    .paddr_o     (paddr_o),
    .target_o    (tgt)
  );

  assign target_o   = tgt;
  assign unmapped_o = (tgt == TGT_NONE);

endmodule

// File: tb/bus_addr_remap_tb.sv
module bus_addr_remap_tb;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [23:0] tag;
    logic [1:0]  cls;
    logic [31:0] fab;
    logic [31:0] ddr;
    logic [31:0] va;
    logic [31:0] pa;
    logic [1:0]  tgt;
  } vec_t;

  // cls: 0 sys 1 dma 2 fab 3 sys; tgt: 0 nvm 1 sram 2 ddr 3 none
  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{"R5 ", 2'd0, 32'h0,         32'h0,    32'h0000_1234, 32'h6000_1234, 2'd0},
    '{"R5 ", 2'd0, 32'h0,         32'h0,    32'h1000_0000, 32'h1000_0000, 2'd3},
    '{"R3 ", 2'd2, 32'h0,         32'h0,    32'h2000_0100, 32'h2000_0100, 2'd1},
    '{"R4 ", 2'd1, 32'h0,         32'h0,    32'h6ABC_0000, 32'h6ABC_0000, 2'd0},
    '{"R6 ", 2'd2, 32'h8000_0003, 32'h0,    32'h0000_0010, 32'h6000_3010, 2'd0},
    '{"R6 ", 2'd2, 32'h8000_0003, 32'h0,    32'h0FFF_D000, 32'h0FFF_D000, 2'd3},
    '{"R6 ", 2'd2, 32'h0,         32'h0,    32'h0000_0010, 32'h0000_0010, 2'd3},
    '{"R6 ", 2'd2, 32'h8000_0003, 32'h1,    32'h0000_0010, 32'h6000_3010, 2'd0},
    '{"R7 ", 2'd0, 32'h0,         32'h10,   32'h8000_0040, 32'h4000_0040, 2'd2},
    '{"R7 ", 2'd2, 32'h0,         32'h30,   32'hBFFF_FFFC, 32'hFFFF_FFFC, 2'd2},
    '{"R8 ", 2'd0, 32'h0,         32'h2011, 32'h0000_0100, 32'h5000_0100, 2'd2},
    '{"R8 ", 2'd0, 32'h0,         32'h2011, 32'h0800_0000, 32'h0800_0000, 2'd3},
    '{"R9 ", 2'd0, 32'h0,         32'h3101, 32'h0000_0020, 32'h1000_0020, 2'd2},
    '{"R9 ", 2'd0, 32'h0,         32'h3301, 32'h1FFF_FFF0, 32'h1FFF_FFF0, 2'd2},
    '{"R10", 2'd1, 32'h0,         32'h2011, 32'h0000_0100, 32'h0000_0100, 2'd2},
    '{"R10", 2'd1, 32'h0,         32'h0,    32'hF000_0000, 32'hF000_0000, 2'd2},
    '{"R11", 2'd0, 32'h0,         32'h0,    32'h3000_0000, 32'h3000_0000, 2'd3},
    '{"R3 ", 2'd3, 32'h0,         32'h0,    32'h0000_0004, 32'h6000_0004, 2'd0},
    '{"R3 ", 2'd0, 32'h0,         32'h2011, 32'h2000_0004, 32'h2000_0004, 2'd1}
  };

  logic        clk, rst_n, we;
  logic [1:0]  raddr, cls, tgt;
  logic [31:0] wdata, rdata, va, pa;
  logic        unm;
  int total = 0;
  int bad   = 0;

  bus_addr_remap u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(raddr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mst_class_i(cls),
    .vaddr_i(va), .paddr_o(pa), .target_o(tgt), .unmapped_o(unm)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; raddr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic req(input string tag, input logic [1:0] c, input logic [31:0] v,
                     input logic [31:0] ep, input logic [1:0] et);
    cls = c; va = v;
    #1;
    check(tag, pa, ep);
    check(tag, {30'b0, tgt}, {30'b0, et});
    check(tag, {31'b0, unm}, {31'b0, et == 2'd3});  // R11 flag
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; we = 1'b0; raddr = 2'd0; wdata = '0; cls = 2'd0; va = '0;
    #(CLK_PERIOD * 3);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    raddr = 2'd0; #1; check("R1", rdata, 32'h0);
    raddr = 2'd1; #1; check("R1", rdata, 32'h0);
    req("R1", 2'd0, 32'h0, 32'h6000_0000, 2'd0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      wr(2'd0, VECS[i].fab);
      wr(2'd1, VECS[i].ddr);
      req(string'(VECS[i].tag), VECS[i].cls, VECS[i].va, VECS[i].pa, VECS[i].tgt);
    end

    // R2 read-back masking and unused words
    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd1, 32'hFFFF_FFFF);
    raddr = 2'd0; #1; check("R2", rdata, 32'h8000_FFFF);
    raddr = 2'd1; #1; check("R2", rdata, 32'h0000_3331);
    wr(2'd2, 32'h0000_0000);
    wr(2'd3, 32'h0000_0000);
    raddr = 2'd2; #1; check("R2", rdata, 32'h0);
    raddr = 2'd3; #1; check("R2", rdata, 32'h0);
    raddr = 2'd0; #1; check("R2", rdata, 32'h8000_FFFF);
    raddr = 2'd1; #1; check("R2", rdata, 32'h0000_3331);

    // R9 size 01 with index 2: bit 12 is 0, so sub-region 0
    wr(2'd1, 32'h0000_2101);
    req("R9", 2'd0, 32'h0000_0040, 32'h0000_0040, 2'd2);

    // R12 write takes effect at the capturing edge
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h0);
    @(negedge clk);
    we = 1'b1; raddr = 2'd0; wdata = 32'h8000_0001;
    req("R12", 2'd2, 32'h0, 32'h0, 2'd3);
    @(posedge clk);
    #1;
    check("R12", pa, 32'h6000_1000);
    check("R12", {30'b0, tgt}, 32'd0);
    @(negedge clk);
    we = 1'b0;
    // R12 combinational response with no clock edge
    va = 32'h0000_0008; #1;
    check("R12", pa, 32'h6000_1008);
    cls = 2'd1; #1;
    check("R12", pa, 32'h0000_0008);
    check("R12", {30'b0, tgt}, 32'd2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule